// File: doc/BRIEF.md
# Oversampled Sync Pulse Generator

This block produces two pulse trains from a free-running nanosecond time count that is assumed to be aligned with the network's distributed clock already. A slow cycle pulse marks each bus cycle. A fast sample pulse fires several times per cycle, and an oversampling factor sets how many. A signed shift moves the whole train earlier or later against the nominal grid. Several instances that are given the same time, cycle time and start time therefore act together even when they sit far apart.

Each sample pulse copies one word from a two-bank sample store into the register that drives a converter. The store's index is the pulse's position inside the cycle. Software fills the back bank during a cycle. The banks trade places on the cycle pulse, so a whole cycle of samples is always presented together.

When enable rises, the configuration is captured and a serial divider works out the sample period. The pulses then begin at the first cycle boundary at or after the start time. Configuration is expected to stay constant while enable is high.

Top module: `osync_pulse_gen`

## Requirements
- R1: Sample pulses come only from comparing the time input with the scheduled instant. A pulse is asserted on the clock after the first edge at which `time_ns` is greater than or equal to that instant.
- R2: The sample period is `cycle_ns / factor`, rounded down. A factor of 0 is treated as 1.
- R3: The cycle pulse is asserted together with the sample pulse of index 0. Cycle boundaries lie at exact multiples of `cycle_ns` from the first boundary, so rounding of the period does not accumulate.
- R4: When the shift is zero or positive, the first boundary is `start_ns + shift_ns`. When it is negative, the first boundary is `start_ns + cycle_ns + shift_ns`. The magnitude of the shift is less than `cycle_ns`.
- R5: Each pulse is high for one clock, provided the sample period is at least one time step per clock. `cycle_pulse` is never high without `sample_pulse`.
- R6: `sample_idx` shows the index, from 0 to factor-1, of the latest sample pulse. It is updated together with that pulse.
- R7: While `enable` is low, both pulses stay low and `sample_idx` is 0 from the next clock on.
- R8: On each sample pulse with index below DEPTH, `dac_out` loads entry `sample_idx` of the front bank. `dac_out` changes at no other time.
- R9: Writes always go to the back bank. The banks swap on each cycle pulse, and the sample at index 0 already reads the newly swapped front bank. While disabled, the bank select returns to its initial state, so words written before enable are the ones shown in the first cycle.
- R10: A sample pulse whose index is DEPTH or more leaves `dac_out` unchanged.
- R11: Two instances that share time, cycle time, shift, start and enable produce coincident cycle pulses even when their factors differ. Sample instants common to both grids also coincide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the generator; a rising level captures the configuration |
| time_ns | input | TIME_W | Synchronised time in nanoseconds |
| cycle_ns | input | CYC_W | Bus cycle time in nanoseconds |
| factor | input | FAC_W | Oversampling factor (samples per cycle) |
| shift_ns | input | CYC_W | Signed shift of the sample train in nanoseconds |
| start_ns | input | CYC_W | Earliest time of the first cycle boundary |
| wr_en | input | 1 | Write strobe into the back bank |
| wr_addr | input | log2(DEPTH) | Back-bank word address |
| wr_data | input | DATA_W | Back-bank write data |
| sample_pulse | output | 1 | One-clock sample strobe |
| cycle_pulse | output | 1 | One-clock cycle strobe |
| sample_idx | output | FAC_W | Index of the latest sample inside its cycle |
| dac_out | output | DATA_W | Converter output register |

## Verification
A wrong next-instant or boundary register shows on the first pulse after it goes wrong. The pulse lands at a different time value from the grid computed in the bench, and with the rounding case a drifting boundary is visible within one cycle. A wrong index or bank select shows up on the very pulse it affects, as a wrong `sample_idx`, a missing cycle flag or a word from the other bank on `dac_out`. Stale state after a disable shows either as a stray pulse or a non-zero index during the quiet window, or as the wrong bank in the first cycle of the next run.

// File: rtl/osg_pkg.sv
package osg_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_DIV  = 2'd1,
      ST_RUN  = 2'd2
   } osg_state_e;
endpackage

// File: rtl/osg_div.sv
module osg_div #(
   parameter int NUM_W = 32,
   parameter int DEN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [NUM_W-1:0] num,
   input  logic [DEN_W-1:0] den,
   output logic             done,
   output logic [NUM_W-1:0] quo
);
   localparam int CNT_W = $clog2(NUM_W + 1);

   logic [NUM_W-1:0] q_r;
   logic [DEN_W-1:0] rem_r, den_r;
   logic [CNT_W-1:0] cnt_r;
   logic [DEN_W:0]   rem_sh;
   logic             ge;

   assign rem_sh = {rem_r, q_r[NUM_W-1]};
   assign ge     = rem_sh >= {1'b0, den_r};
   assign quo    = q_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_r   <= '0;
         rem_r <= '0;
         den_r <= '0;
         cnt_r <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            q_r   <= num;
            rem_r <= '0;
            den_r <= den;
            cnt_r <= CNT_W'(NUM_W);
         end else if (cnt_r != '0) begin
            q_r   <= {q_r[NUM_W-2:0], ge};
            rem_r <= ge ? DEN_W'(rem_sh - {1'b0, den_r}) : rem_sh[DEN_W-1:0];
            cnt_r <= cnt_r - 1'b1;
            if (cnt_r == CNT_W'(1)) done <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/osg_sched.sv
module osg_sched
   import osg_pkg::*;
#(
   parameter int TIME_W = 64,
   parameter int CYC_W  = 32,
   parameter int FAC_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [TIME_W-1:0] time_ns,
   input  logic [CYC_W-1:0]  cycle_ns,
   input  logic [FAC_W-1:0]  factor,
   input  logic [CYC_W-1:0]  shift_ns,
   input  logic [CYC_W-1:0]  start_ns,
   output logic              hit,
   output logic              hit_cyc,
   output logic [FAC_W-1:0]  hit_idx,
   output logic              idle,
   output logic              sample_pulse,
   output logic              cycle_pulse,
   output logic [FAC_W-1:0]  sample_idx
);
   osg_state_e        state_q;
   logic [CYC_W-1:0]  cyc_q, per_q, sh_q, st_q;
   logic [FAC_W-1:0]  fac_q, idx_q, fac_eff;
   logic [TIME_W-1:0] bnd_q, nxt_q, shift_ext, first_bnd, next_bnd;
   logic [CYC_W-1:0]  div_q;
   logic              div_go, div_done, last;

   assign fac_eff   = (factor == '0) ? FAC_W'(1) : factor;
   assign div_go    = (state_q == ST_IDLE) && enable;
   assign shift_ext = {{(TIME_W-CYC_W){sh_q[CYC_W-1]}}, sh_q};
   assign first_bnd = TIME_W'(st_q) + shift_ext
                    + (sh_q[CYC_W-1] ? TIME_W'(cyc_q) : '0);
   assign next_bnd  = bnd_q + TIME_W'(cyc_q);
   assign last      = (idx_q == fac_q - 1'b1);

   assign hit     = enable && (state_q == ST_RUN) && (time_ns >= nxt_q);
   assign hit_cyc = (idx_q == '0);
   assign hit_idx = idx_q;
   assign idle    = (state_q == ST_IDLE);

   osg_div #(.NUM_W(CYC_W), .DEN_W(FAC_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .start (div_go),
      .num   (cycle_ns),
      .den   (fac_eff),
      .done  (div_done),
      .quo   (div_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         cyc_q        <= '0;
         per_q        <= '0;
         sh_q         <= '0;
         st_q         <= '0;
         fac_q        <= FAC_W'(1);
         idx_q        <= '0;
         bnd_q        <= '0;
         nxt_q        <= '0;
         sample_pulse <= 1'b0;
         cycle_pulse  <= 1'b0;
         sample_idx   <= '0;
      end else if (!enable) begin
         state_q      <= ST_IDLE;
         idx_q        <= '0;
         sample_pulse <= 1'b0;
         cycle_pulse  <= 1'b0;
         sample_idx   <= '0;
      end else begin
         sample_pulse <= hit;
         cycle_pulse  <= hit && hit_cyc;
         if (hit) sample_idx <= idx_q;
         unique case (state_q)
            ST_IDLE: begin
               cyc_q   <= cycle_ns;
               fac_q   <= fac_eff;
               sh_q    <= shift_ns;
               st_q    <= start_ns;
               state_q <= ST_DIV;
            end
            ST_DIV: if (div_done) begin
               per_q   <= div_q;
               bnd_q   <= first_bnd;
               nxt_q   <= first_bnd;
               idx_q   <= '0;
               state_q <= ST_RUN;
            end
            ST_RUN: if (hit) begin
               if (last) begin
                  idx_q <= '0;
                  bnd_q <= next_bnd;
                  nxt_q <= next_bnd;
               end else begin
                  idx_q <= idx_q + 1'b1;
                  nxt_q <= nxt_q + TIME_W'(per_q);
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/osg_bank.sv
module osg_bank #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 128,
   parameter int IDX_W  = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clear,
   input  logic                       wr_en,
   input  logic [$clog2(DEPTH)-1:0]   wr_addr,
   input  logic [DATA_W-1:0]          wr_data,
   input  logic                       hit,
   input  logic                       hit_cyc,
   input  logic [IDX_W-1:0]           hit_idx,
   output logic [DATA_W-1:0]          dac_out
);
   localparam int ADDR_W = $clog2(DEPTH);

   logic              sel_q, wr_bank, rd_bank, in_range;
   logic [DATA_W-1:0] rd_word [2];

   assign wr_bank  = ~sel_q;
   assign rd_bank  = hit_cyc ? ~sel_q : sel_q;
   assign in_range = hit_idx < IDX_W'(DEPTH);

   for (genvar b = 0; b < 2; b++) begin : g_bank
      logic [DATA_W-1:0] mem [DEPTH];
      always_ff @(posedge clk) begin
         if (wr_en && (wr_bank == 1'(b))) mem[wr_addr] <= wr_data;
      end
      assign rd_word[b] = mem[hit_idx[ADDR_W-1:0]];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q   <= 1'b0;
         dac_out <= '0;
      end else begin
         if (clear) sel_q <= 1'b0;
         else if (hit && hit_cyc) sel_q <= ~sel_q;
         if (hit && in_range) dac_out <= rd_word[rd_bank];
      end
   end
endmodule

// File: rtl/osync_pulse_gen.sv
module osync_pulse_gen #(
   parameter int TIME_W = 64,
   parameter int CYC_W  = 32,
   parameter int FAC_W  = 16,
   parameter int DATA_W = 16,
   parameter int DEPTH  = 128
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     enable,
   input  logic [TIME_W-1:0]        time_ns,
   input  logic [CYC_W-1:0]         cycle_ns,
   input  logic [FAC_W-1:0]         factor,
   input  logic [CYC_W-1:0]         shift_ns,
   input  logic [CYC_W-1:0]         start_ns,
   input  logic                     wr_en,
   input  logic [$clog2(DEPTH)-1:0] wr_addr,
   input  logic [DATA_W-1:0]        wr_data,
   output logic                     sample_pulse,
   output logic                     cycle_pulse,
   output logic [FAC_W-1:0]         sample_idx,
   output logic [DATA_W-1:0]        dac_out
);
   localparam int ADDR_W = $clog2(DEPTH);

   if (TIME_W <= CYC_W) begin : g_bad_time
      $error("TIME_W must exceed CYC_W");
   end
   if ((1 << ADDR_W) != DEPTH || DEPTH < 2) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (DEPTH >= (1 << FAC_W) || FAC_W > CYC_W) begin : g_bad_fac
      $error("FAC_W must cover DEPTH and fit in CYC_W");
   end

   logic             hit, hit_cyc, idle;
   logic [FAC_W-1:0] hit_idx;

   osg_sched #(.TIME_W(TIME_W), .CYC_W(CYC_W), .FAC_W(FAC_W)) u_sched (
      .clk          (clk),
      .rst_n        (rst_n),
      .enable       (enable),
      .time_ns      (time_ns),
      .cycle_ns     (cycle_ns),
      .factor       (factor),
      .shift_ns     (shift_ns),
      .start_ns     (start_ns),
      .hit          (hit),
      .hit_cyc      (hit_cyc),
      .hit_idx      (hit_idx),
      .idle         (idle),
      .sample_pulse (sample_pulse),
      .cycle_pulse  (cycle_pulse),
      .sample_idx   (sample_idx)
   );

   osg_bank #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(FAC_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (idle),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .hit     (hit),
      .hit_cyc (hit_cyc),
      .hit_idx (hit_idx),
      .dac_out (dac_out)
   );
endmodule

// File: rtl/osg_chk.sv
module osg_chk #(
   parameter int FAC_W  = 16,
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              enable,
   input logic              sample_pulse,
   input logic              cycle_pulse,
   input logic [FAC_W-1:0]  sample_idx,
   input logic [DATA_W-1:0] dac_out
);
   logic [FAC_W-1:0] last_idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_idx <= '0;
      else if (sample_pulse) last_idx <= sample_idx;
   end

   p_cyc_with_sample_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cycle_pulse |-> sample_pulse);

   p_single_clk_r5: assert property (@(posedge clk) disable iff (!rst_n)
      sample_pulse |=> !sample_pulse);

   p_cyc_idx_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cycle_pulse |-> sample_idx == '0);

   p_idx_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_pulse && !cycle_pulse) |-> sample_idx == FAC_W'(last_idx + 1'b1));

   p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (!sample_pulse && sample_idx == '0));

   p_dac_on_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dac_out) |-> sample_pulse);
endmodule

bind osync_pulse_gen osg_chk #(.FAC_W(FAC_W), .DATA_W(DATA_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .enable       (enable),
   .sample_pulse (sample_pulse),
   .cycle_pulse  (cycle_pulse),
   .sample_idx   (sample_idx),
   .dac_out      (dac_out)
);

// File: tb/osync_pulse_gen_tb.sv
module osync_pulse_gen_tb;
   localparam int DEPTH = 128;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] time_ns;
   logic        enable = 1'b0, peer_en = 1'b0, wr_en = 1'b0;
   logic [31:0] cycle_ns = 32'd1000, start_ns = '0, shift_ns = '0;
   logic [15:0] factor = 16'd1;
   logic [6:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic        sample_pulse, cycle_pulse, p_sample, p_cycle;
   logic [15:0] sample_idx, dac_out, p_idx, p_dac;

   always #5 clk = ~clk;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) time_ns <= '0;
      else        time_ns <= time_ns + 64'd10;

   osync_pulse_gen u_dut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .time_ns(time_ns),
      .cycle_ns(cycle_ns), .factor(factor), .shift_ns(shift_ns), .start_ns(start_ns),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .sample_pulse(sample_pulse), .cycle_pulse(cycle_pulse),
      .sample_idx(sample_idx), .dac_out(dac_out));

   osync_pulse_gen u_peer (
      .clk(clk), .rst_n(rst_n), .enable(peer_en), .time_ns(time_ns),
      .cycle_ns(cycle_ns), .factor(16'd2), .shift_ns(shift_ns), .start_ns(start_ns),
      .wr_en(1'b0), .wr_addr(7'd0), .wr_data(16'd0),
      .sample_pulse(p_sample), .cycle_pulse(p_cycle),
      .sample_idx(p_idx), .dac_out(p_dac));

   typedef struct {
      longint t;
      int     idx;
      bit     cyc;
      int     dac;
   } exp_t;

   exp_t q[$];
   int   n_cmp = 0, n_bad = 0;
   int   m0 [DEPTH];
   int   m1 [DEPTH];
   bit   peer_chk = 1'b0, prev_sp = 1'b0, finished = 1'b0;

   task automatic check(bit ok, string tag, longint act, longint expv);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
      end
   endtask

   function automatic longint up10(longint v);
      return ((v + 9) / 10) * 10;
   endfunction

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   // monitor: pops expected pulses as the design produces them
   always @(negedge clk) begin
      if (rst_n) begin
         if (cycle_pulse && !sample_pulse) check(0, "R5 cycle pulse alone", 1, 0);
         if (sample_pulse && prev_sp) check(0, "R5 pulse longer than one clock", 2, 1);
         prev_sp = sample_pulse;
         if (sample_pulse) begin
            if (q.size() == 0) check(0, "R1 unexpected sample pulse", 1, 0);
            else begin
               exp_t e;
               longint obs;
               e   = q.pop_front();
               obs = longint'(time_ns) - 10;
               check(obs == up10(e.t), "R1 R2 R4 pulse instant", obs, up10(e.t));
               check(cycle_pulse == e.cyc, "R3 cycle flag", cycle_pulse, e.cyc);
               check(int'(sample_idx) == e.idx, "R6 sample index", sample_idx, e.idx);
               check(int'(dac_out) == e.dac,
                     (e.idx >= DEPTH) ? "R10 dac hold beyond depth" : "R8 R9 dac word",
                     dac_out, e.dac);
            end
         end
         if (peer_chk && (cycle_pulse || p_cycle))
            check(cycle_pulse == p_cycle, "R11 cycle pulses aligned", p_cycle, cycle_pulse);
         if (peer_chk && p_sample)
            check(sample_pulse, "R11 shared sample instant", sample_pulse, 1);
      end
   end

   task automatic wr(int addr, int data);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 7'(addr); wr_data = 16'(data);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // driver: writes the back bank, pushes the expected pulse list, enables
   task automatic phase_start(int fac, int cyc, int sh, int ncyc, int base, int nwr, bit with_peer);
      longint start, bnd, per;
      enable = 1'b0;
      repeat (4) @(negedge clk);
      for (int i = 0; i < nwr; i++) begin
         wr(i, base + i);
         m1[i] = base + i;
      end
      start = ((longint'(time_ns) / 1000) + 3) * 1000;
      bnd   = (sh >= 0) ? start + sh : start + cyc + sh;   // R4
      per   = cyc / fac;                                   // R2 rounded-down period
      for (int k = 0; k < ncyc; k++) begin
         for (int j = 0; j < fac; j++) begin
            exp_t e;
            int   jj;
            jj    = (j < DEPTH) ? j : DEPTH - 1;
            e.t   = bnd + longint'(k) * cyc + longint'(j) * per;  // R3 exact boundary
            e.idx = j;
            e.cyc = (j == 0);
            e.dac = (k % 2 == 0) ? m1[jj] : m0[jj];                // R9 bank alternation
            q.push_back(e);
         end
      end
      factor   = 16'(fac);
      cycle_ns = 32'(cyc);
      shift_ns = 32'(sh);
      start_ns = 32'(start);
      peer_en  = with_peer;
      peer_chk = with_peer;
      enable   = 1'b1;
   endtask

   task automatic phase_end();
      bit ok;
      while (q.size() != 0) @(negedge clk);
      enable  = 1'b0;
      peer_en = 1'b0;
      ok = 1'b1;
      repeat (30) begin
         @(negedge clk);
         if (sample_pulse || sample_idx != 0) ok = 1'b0;
      end
      peer_chk = 1'b0;
      check(ok, "R7 quiet while disabled", !ok, 0);
   endtask

   initial begin
      for (int i = 0; i < DEPTH; i++) begin m0[i] = 0; m1[i] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(sample_pulse == 1'b0, "R5 reset sample pulse", sample_pulse, 0);
      check(cycle_pulse == 1'b0, "R3 reset cycle pulse", cycle_pulse, 0);
      check(sample_idx == 16'd0, "R6 reset index", sample_idx, 0);
      check(dac_out == 16'd0, "R8 reset dac", dac_out, 0);

      // A: factor 4, no shift; bank 0 refilled during the first cycle; peer with factor 2
      for (int i = 0; i < 8; i++) m0[i] = 16'h2200 + i;
      phase_start(4, 1000, 0, 4, 16'h1100, 8, 1'b1);
      do @(negedge clk); while (!cycle_pulse);
      for (int i = 0; i < 8; i++) wr(i, 16'h2200 + i);
      phase_end();

      // B: factor 3 with rounded period and positive shift
      phase_start(3, 1000, 50, 3, 16'h3300, 3, 1'b0);
      phase_end();

      // C: factor 5 with negative shift
      phase_start(5, 1000, -100, 3, 16'h4400, 5, 1'b0);
      phase_end();

      // D: factor 1, every pulse is a cycle pulse and swaps banks
      phase_start(1, 500, 0, 4, 16'h6600, 1, 1'b0);
      phase_end();

      // E: factor beyond depth, indices 128 and 129 hold the last word (R10)
      phase_start(130, 13000, 0, 1, 16'h5000, DEPTH, 1'b0);
      phase_end();

      finished = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         summary();
         $finish;
      end
   end
endmodule